// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplexer Modes

This block holds a row of single-bit outputs, 2^SEL_W of them (eight by default). It is driven by one data bit, a binary select, an active-low enable and an active-low clear. The two control pins together choose one of four modes.

- **Write**: clear high, enable low. The selected bit is updated on each rising clock edge.
- **Hold**: both pins high. Every bit keeps its value.
- **Demultiplex**: both pins low. The selected output follows the data bit and every other output is low.
- **Clear**: clear low, enable high. Every output is low.

It is used as a small working register or as a one-of-N decoder. In that use, the enable lets several copies share the data and low select lines while a higher-order decode picks the active copy.

Writes are clocked: the bit present at the last rising edge with the enable low is the one retained. Outputs in write and hold modes show the stored contents. In demultiplex and clear modes they follow the inputs without waiting for a clock, and pulling clear low erases the stored contents asynchronously. There is no streaming data path, so all pins are plain level signals with no handshake.

Top module: `addr_latch_demux`

## Requirements
- R1: In write mode (clr_n_i=1, en_n_i=0), after a rising clock edge, output bit number sel_i (plain binary value: 0 selects q_o[0], all ones selects the top bit) equals the data_i sampled at that edge.
- R2: In write mode, every output bit other than the selected one keeps its value across the edge.
- R3: In hold mode (clr_n_i=1, en_n_i=1), all outputs keep their values whatever data_i and sel_i do.
- R4: In demultiplex mode (clr_n_i=0, en_n_i=0), q_o[sel_i] equals data_i and all other outputs are 0, with no clock needed.
- R5: In clear mode (clr_n_i=0, en_n_i=1), all outputs are 0 regardless of sel_i and data_i.
- R6: Clear is asynchronous. A low pulse on clr_n_i between clock edges, with en_n_i=1, drives all outputs to 0 at once. The stored contents stay erased after clr_n_i returns high.
- R7: Each select value 0 to 2^SEL_W-1 addresses exactly one distinct output bit, the one whose index equals the select value.
- R8: On leaving demultiplex mode, every non-selected bit stays 0. The selected bit keeps the data value present at the last clock edge in that mode.
- R9: The value retained after the enable returns high is data_i at the last rising edge with en_n_i low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes are taken on the rising edge |
| clr_n_i | input | 1 | Active-low clear (asynchronous) and mode select |
| en_n_i | input | 1 | Active-low enable and mode select |
| sel_i | input | SEL_W | Binary select of the addressed bit |
| data_i | input | 1 | Data bit written or demultiplexed |
| q_o | output | 2^SEL_W | Output bits |

## Verification
The checker assumes that sel_i never changes between two clock edges at which en_n_i is low. This is the usual rule that the address moves only while the enable is inactive, and a property states it. The write and hold properties are turned off for any clock interval in which clr_n_i went low, because an asynchronous clear legitimately breaks the edge-to-edge relation they check. The stimulus changes the select only in cycles where the enable was high, or where it rises again. It places asynchronous clear pulses half a cycle away from any edge, with the enable high.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } latch_mode_e;
endpackage

// File: rtl/alc_mode_decode.sv
module alc_mode_decode
  import addr_latch_pkg::*;
(
  input  logic        clr_n_i,
  input  logic        en_n_i,
  output latch_mode_e mode_o
);
  always_comb begin
    unique case ({clr_n_i, en_n_i})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alc_bit_store.sv
module alc_bit_store
  import addr_latch_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic             en_n_i,
  input  latch_mode_e      mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             data_i,
  output logic [OUT_W-1:0] state_o
);
  // Demux capture is reset only by clear mode, so it survives clear-low writes.
  logic keep_rst_n;
  assign keep_rst_n = clr_n_i | ~en_n_i;

  for (genvar b = 0; b < OUT_W; b++) begin : g_bit
    logic hit;
    logic main_q;
    logic keep_q;

    assign hit        = (sel_i == SEL_W'(b));
    assign state_o[b] = main_q | keep_q;

    always_ff @(posedge clk_i or negedge clr_n_i) begin
      if (!clr_n_i) begin
        main_q <= 1'b0;
      end else if (mode_i == MODE_WRITE && hit) begin
        main_q <= data_i;
      end else begin
        main_q <= state_o[b];
      end
    end

    always_ff @(posedge clk_i or negedge keep_rst_n) begin
      if (!keep_rst_n) begin
        keep_q <= 1'b0;
      end else if (mode_i == MODE_DEMUX) begin
        keep_q <= hit & data_i;
      end else begin
        keep_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alc_out_mux.sv
module alc_out_mux
  import addr_latch_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  latch_mode_e      mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             data_i,
  input  logic [OUT_W-1:0] state_i,
  output logic [OUT_W-1:0] q_o
);
  logic [OUT_W-1:0] onehot;

  for (genvar b = 0; b < OUT_W; b++) begin : g_dec
    assign onehot[b] = (sel_i == SEL_W'(b)) & data_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_DEMUX: q_o = onehot;
      MODE_CLEAR: q_o = '0;
      default:    q_o = state_i;
    endcase
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import addr_latch_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic             en_n_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             data_i,
  output logic [OUT_W-1:0] q_o
);
  latch_mode_e      mode;
  logic [OUT_W-1:0] state;

  alc_mode_decode u_mode (
    .clr_n_i (clr_n_i),
    .en_n_i  (en_n_i),
    .mode_o  (mode)
  );

  alc_bit_store #(.SEL_W(SEL_W)) u_store (
    .clk_i   (clk_i),
    .clr_n_i (clr_n_i),
    .en_n_i  (en_n_i),
    .mode_i  (mode),
    .sel_i   (sel_i),
    .data_i  (data_i),
    .state_o (state)
  );

  alc_out_mux #(.SEL_W(SEL_W)) u_out (
    .mode_i  (mode),
    .sel_i   (sel_i),
    .data_i  (data_i),
    .state_i (state),
    .q_o     (q_o)
  );
endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input logic             clk_i,
  input logic             clr_n_i,
  input logic             en_n_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             data_i,
  input logic [OUT_W-1:0] q_o
);
  logic seen_q = 1'b0;
  logic clr_hit_q;

  always_ff @(posedge clk_i) seen_q <= 1'b1;

  // Set if clear went low at any time since the previous edge.
  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) clr_hit_q <= 1'b1;
    else          clr_hit_q <= 1'b0;
  end

  assert_write_bit_R1: assert property (@(posedge clk_i)
    disable iff (!seen_q || clr_hit_q)
    (clr_n_i && $past(clr_n_i) && !$past(en_n_i)) |-> q_o[$past(sel_i)] == $past(data_i));

  assert_write_others_R2: assert property (@(posedge clk_i)
    disable iff (!seen_q || clr_hit_q)
    (clr_n_i && $past(clr_n_i) && $past(clr_n_i && !en_n_i)) |->
      ((q_o & ~(OUT_W'(1) << $past(sel_i))) == ($past(q_o) & ~(OUT_W'(1) << $past(sel_i)))));

  assert_hold_stable_R3: assert property (@(posedge clk_i)
    disable iff (!seen_q || clr_hit_q)
    (clr_n_i && en_n_i && $past(clr_n_i && en_n_i)) |-> $stable(q_o));

  assert_demux_onehot_R4: assert property (@(posedge clk_i)
    disable iff (!seen_q)
    (!clr_n_i && !en_n_i) |-> (q_o == (OUT_W'(data_i) << sel_i)));

  assert_clear_zero_R5: assert property (@(posedge clk_i)
    disable iff (!seen_q)
    (!clr_n_i && en_n_i) |-> (q_o == '0));

  assert_sel_steady_enabled: assert property (@(posedge clk_i)
    disable iff (!seen_q)
    (!en_n_i && !$past(en_n_i)) |-> $stable(sel_i));
endmodule

bind addr_latch_demux addr_latch_demux_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i   (clk_i),
  .clr_n_i (clr_n_i),
  .en_n_i  (en_n_i),
  .sel_i   (sel_i),
  .data_i  (data_i),
  .q_o     (q_o)
);

// File: tb/addr_latch_demux_bench.sv
`timescale 1ns/1ps
module addr_latch_demux_bench;
  localparam int SEL_W = 3;
  localparam int OUT_W = 1 << SEL_W;

  logic             clk = 1'b0;
  logic             clr_n = 1'b0;
  logic             en_n = 1'b1;
  logic [SEL_W-1:0] sel = '0;
  logic             data = 1'b0;
  logic [OUT_W-1:0] q;

  logic [OUT_W-1:0] model = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  addr_latch_demux #(.SEL_W(SEL_W)) u_addr_latch_demux (
    .clk_i   (clk),
    .clr_n_i (clr_n),
    .en_n_i  (en_n),
    .sel_i   (sel),
    .data_i  (data),
    .q_o     (q)
  );

  function automatic logic [OUT_W-1:0] expect_q();
    case ({clr_n, en_n})
      2'b00:   return OUT_W'(data) << sel;
      2'b01:   return '0;
      default: return model;
    endcase
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs at the falling edge, check outputs, then let the model take the rising edge.
  task automatic step(input logic c, input logic e, input logic [SEL_W-1:0] s,
                      input logic d, input string req);
    @(negedge clk);
    clr_n = c; en_n = e; sel = s; data = d;
    if (!c) model = '0;
    #1;
    check(req, q, expect_q());
    @(posedge clk);
    case ({c, e})
      2'b10: model[s] = d;
      2'b00: begin model = '0; model[s] = d; end
      2'b01: model = '0;
      default: ;
    endcase
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    en_n = 1'b1; clr_n = 1'b0;
    #0.5;
    check("R6 async clear", q, '0);
    model = '0;
    clr_n = 1'b1;
    #0.5;
    check("R6 erased after release", q, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: q=%b expected completion", q);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [SEL_W-1:0] cur_sel;
    logic prev_en;
    // Reset state in clear mode: R5
    step(1'b0, 1'b1, 3'd5, 1'b1, "R5 reset clear");
    step(1'b0, 1'b1, 3'd2, 1'b1, "R5 clear ignores inputs");
    // Walk every select writing ones: R7, R1, R2
    for (int k = 0; k < OUT_W; k++) begin
      step(1'b1, 1'b1, SEL_W'(k), 1'b1, "R7 select set");
      step(1'b1, 1'b0, SEL_W'(k), 1'b1, "R7 write");
      step(1'b1, 1'b1, SEL_W'(k), 1'b0, "R1 R2 bit written");
      check("R7 accumulated ones", q, OUT_W'((1 << (k + 1)) - 1));
    end
    // Hold mode ignores data and select: R3
    step(1'b1, 1'b1, 3'd3, 1'b0, "R3 hold");
    step(1'b1, 1'b1, 3'd6, 1'b1, "R3 hold");
    check("R3 hold all ones", q, '1);
    // Clear one bit by writing zero: R1 R2
    step(1'b1, 1'b0, 3'd4, 1'b0, "R1 write zero");
    step(1'b1, 1'b1, 3'd4, 1'b0, "R2 others held");
    check("R2 only bit 4 cleared", q, 8'b1110_1111);
    // Last enabled edge wins: R9
    step(1'b1, 1'b1, 3'd2, 1'b0, "R9 select");
    step(1'b1, 1'b0, 3'd2, 1'b0, "R9 write zero");
    step(1'b1, 1'b0, 3'd2, 1'b1, "R9 write one");
    step(1'b1, 1'b1, 3'd2, 1'b0, "R9 enable released");
    check("R9 retained last value", q, 8'b1110_1111);
    // Asynchronous clear between edges: R6
    clear_pulse();
    step(1'b1, 1'b1, 3'd0, 1'b1, "R6 stays erased");
    // Demux mode: R4, then exit: R8
    step(1'b1, 1'b1, 3'd5, 1'b1, "R8 prepare");
    step(1'b1, 1'b0, 3'd1, 1'b1, "R8 write bit 1");
    step(1'b1, 1'b1, 3'd5, 1'b1, "R8 select 5");
    step(1'b0, 1'b0, 3'd5, 1'b1, "R4 demux one");
    step(1'b0, 1'b0, 3'd5, 1'b0, "R4 demux zero");
    step(1'b0, 1'b0, 3'd5, 1'b1, "R4 demux one again");
    step(1'b1, 1'b1, 3'd0, 1'b0, "R8 exit to hold");
    check("R8 only demuxed bit kept", q, 8'b0010_0000);
    // Random walk over all modes
    cur_sel = '0;
    prev_en = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic c, e, d;
      c = ($urandom_range(0, 3) != 0);
      e = $urandom_range(0, 1);
      d = $urandom_range(0, 1);
      if (prev_en || e) cur_sel = SEL_W'($urandom);
      case ({c, e})
        2'b10:   step(c, e, cur_sel, d, "R1 random write");
        2'b11:   step(c, e, cur_sel, d, "R3 random hold");
        2'b00:   step(c, e, cur_sel, d, "R4 random demux");
        default: step(c, e, cur_sel, d, "R5 random clear");
      endcase
      prev_en = e;
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule